// File: doc/BRIEF.md
# AC97 Receive Slot Checker

This block sits behind the serial data input of an AC97 link and turns the codec's bit stream into 20-bit slot words. At the start of every frame it reads the 16-bit tag slot and takes out the valid bits of the ten data slots (3 to 12). It then compares that pattern with a programmed expected-slot mask. Only when the two are exactly equal does it pass the frame's data words, in ascending slot order, to the write side of a receive FIFO. A frame that carries data in slots that differ from the mask sets a sticky unexpected-slot flag, and that frame's data is thrown away.

The block runs on one system clock. The serial bit clock arrives as a one-cycle strobe, `bit_en`, that marks each cycle in which `sync_in` and `sdata_in` hold a new bit. A frame that is empty, or that carries only status slots, does not count as a mismatch. The checker works only while both the AC97 mode select and the AC97 enable are high. When the FIFO is full at the moment a word is due, the word is dropped and a sticky overrun flag is raised.

Top module: `ac97_rx_slot_check`

## Requirements
- R1: While reset is high and in the first cycle after it, `fifo_wr`, `unexp_flag` and `ovr_flag` are 0.
- R2: A frame begins at the first strobe where `sync_in` is 1 after being 0 at the previous strobe. That bit is tag bit 15. The frame goes on with 15 more tag bits and then twelve 20-bit slots, each sent MSB first. A new rising edge of `sync_in` restarts alignment, even in the middle of a frame.
- R3: `exp_mask` bit i stands for data slot 3+i, and that slot's valid bit is tag bit 12-i (tag bit 15 is the first bit received).
- R4: When the received data-slot valid pattern equals `exp_mask` and is not zero, the block writes one word to the FIFO per enabled slot, in ascending slot order. Each write is a one-cycle `fifo_wr` pulse in the clock after the strobe that carries the slot's last bit. `fifo_data` holds that slot's 20 bits.
- R5: When the valid pattern is nonzero and differs from `exp_mask`, `unexp_flag` rises and none of that frame's words are written.
- R6: A frame whose tag bits 12 to 3 are all zero (an empty frame, or one with only status slots) writes nothing and leaves `unexp_flag` unchanged.
- R7: `unexp_flag` stays set until a cycle in which `clr_unexp` is 1.
- R8: Unless `mode_ac97` and `ac97_en` are both 1, no word is written and `unexp_flag` is not set.
- R9: A word that is due while `fifo_full` is 1 is dropped and sets `ovr_flag`. `ovr_flag` stays set until `clr_ovr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| sync_in | input | 1 | Frame sync line, sampled on `bit_en` |
| sdata_in | input | 1 | Serial data from the codec, sampled on `bit_en` |
| mode_ac97 | input | 1 | AC97 mode selected |
| ac97_en | input | 1 | AC97 receive enable |
| exp_mask | input | 10 | Expected valid data slots; bit i is slot 3+i |
| clr_unexp | input | 1 | Clears the unexpected-slot flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| fifo_full | input | 1 | Receive FIFO cannot take a word |
| fifo_wr | output | 1 | FIFO write pulse |
| fifo_data | output | 20 | Slot word to be written |
| unexp_flag | output | 1 | Sticky unexpected-slot status |
| ovr_flag | output | 1 | Sticky overrun status |

## Verification
The assertions assume three things about the inputs. First, `sync_in` and `sdata_in` change only together with a `bit_en` strobe, and strobes are spaced several clocks apart. Second, `exp_mask` and the mode and enable inputs stay steady for the whole of a frame. Third, the clear inputs are pulsed only between frames. The bench keeps to all three: it drives every bit on a falling clock edge, with the strobe one cycle high out of every four, and it changes configuration, FIFO-full state and clears only while the link is idle between frames.

// File: rtl/ac97_rx_pkg.sv
package ac97_rx_pkg;
  localparam int AC_TAG_W     = 16;  // width of the tag slot
  localparam int AC_SLOT_W    = 20;  // width of slots 1..12
  localparam int AC_NUM_SLOTS = 12;  // slots following the tag slot
  localparam int AC_FIRST_DAT = 3;   // first data slot
  localparam int AC_NUM_DAT   = 10;  // data slots 3..12
  localparam int AC_SLOT_IW   = $clog2(AC_NUM_SLOTS + 1);
endpackage

// File: rtl/ac97_frame_align.sv
module ac97_frame_align
  import ac97_rx_pkg::*;
#(
  parameter int TAG_W   = AC_TAG_W,
  parameter int SLOT_W  = AC_SLOT_W,
  parameter int N_SLOTS = AC_NUM_SLOTS,
  localparam int SW     = $clog2(N_SLOTS + 1),
  localparam int BW     = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              sync_in,
  input  logic              sdata_in,
  output logic              cur_valid,
  output logic              cur_last,
  output logic [SW-1:0]     cur_slot,
  output logic [SLOT_W-1:0] word
);
  logic              sync_q;
  logic              in_frame;
  logic [SW-1:0]     slot_q;
  logic [BW-1:0]     bit_q;
  logic [BW-1:0]     cur_bit;
  logic [SLOT_W-2:0] shreg;
  logic              start;

  assign start = bit_en & sync_in & ~sync_q;

  always_comb begin
    cur_valid = bit_en & (start | in_frame);
    cur_slot  = start ? '0 : slot_q;
    cur_bit   = start ? '0 : bit_q;
    if (cur_slot == '0) cur_last = cur_valid & (cur_bit == BW'(TAG_W - 1));
    else                cur_last = cur_valid & (cur_bit == BW'(SLOT_W - 1));
  end

  assign word = {shreg, sdata_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b0;
      in_frame <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      shreg    <= '0;
    end else if (bit_en) begin
      sync_q <= sync_in;
      shreg  <= {shreg[SLOT_W-3:0], sdata_in};
      if (cur_valid) begin
        if (cur_last) begin
          bit_q <= '0;
          if (cur_slot == SW'(N_SLOTS)) begin
            in_frame <= 1'b0;
            slot_q   <= '0;
          end else begin
            in_frame <= 1'b1;
            slot_q   <= cur_slot + SW'(1);
          end
        end else begin
          in_frame <= 1'b1;
          slot_q   <= cur_slot;
          bit_q    <= cur_bit + BW'(1);
        end
      end
    end
  end

  // R2: position counters stay inside the frame layout
  a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> (slot_q <= SW'(N_SLOTS)));
  a_r2_tag_bit_range: assert property (@(posedge clk) disable iff (rst)
    (in_frame && slot_q == '0) |-> (bit_q < BW'(TAG_W)));
endmodule

// File: rtl/ac97_tag_check.sv
module ac97_tag_check
  import ac97_rx_pkg::*;
#(
  parameter int TAG_W  = AC_TAG_W,
  parameter int FIRST  = AC_FIRST_DAT,
  parameter int N_DAT  = AC_NUM_DAT,
  parameter int SW     = AC_SLOT_IW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cur_valid,
  input  logic             cur_last,
  input  logic [SW-1:0]    cur_slot,
  input  logic [TAG_W-1:0] tag_word,
  input  logic             active,
  input  logic [N_DAT-1:0] exp_mask,
  input  logic             clr_unexp,
  output logic             accept,
  output logic [N_DAT-1:0] slot_en,
  output logic             unexp_flag
);
  logic [N_DAT-1:0] rx_valid;
  logic             in_tag;
  logic             tag_done;
  logic             has_data;
  logic             match;

  for (genvar i = 0; i < N_DAT; i++) begin : g_map
    assign rx_valid[i] = tag_word[TAG_W - 1 - FIRST - i];
  end

  assign in_tag   = cur_valid & (cur_slot == '0);
  assign tag_done = in_tag & cur_last;
  assign has_data = |rx_valid;
  assign match    = (rx_valid == exp_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      accept     <= 1'b0;
      slot_en    <= '0;
      unexp_flag <= 1'b0;
    end else begin
      if (in_tag) begin
        accept  <= tag_done & active & has_data & match;
        slot_en <= rx_valid;
      end
      if (tag_done & active & has_data & ~match) unexp_flag <= 1'b1;
      else if (clr_unexp)                        unexp_flag <= 1'b0;
    end
  end

  // R7: flag holds until cleared
  a_r7_unexp_sticky: assert property (@(posedge clk) disable iff (rst)
    (unexp_flag && !clr_unexp) |=> unexp_flag);
  // R6: an empty or status-only frame never raises the flag
  a_r6_empty_no_flag: assert property (@(posedge clk) disable iff (rst)
    (tag_done && !has_data && !unexp_flag) |=> !unexp_flag);
  // R5: a frame that raises the flag is never accepted
  a_r5_flag_excludes_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(unexp_flag) |-> !accept);
endmodule

// File: rtl/ac97_fifo_feed.sv
module ac97_fifo_feed
  import ac97_rx_pkg::*;
#(
  parameter int SLOT_W = AC_SLOT_W,
  parameter int FIRST  = AC_FIRST_DAT,
  parameter int N_DAT  = AC_NUM_DAT,
  parameter int SW     = AC_SLOT_IW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_valid,
  input  logic              cur_last,
  input  logic [SW-1:0]     cur_slot,
  input  logic [SLOT_W-1:0] word,
  input  logic              accept,
  input  logic [N_DAT-1:0]  slot_en,
  input  logic              active,
  input  logic              fifo_full,
  input  logic              clr_ovr,
  output logic              fifo_wr,
  output logic [SLOT_W-1:0] fifo_data,
  output logic              ovr_flag
);
  logic hit;
  logic due;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_DAT; i++)
      if (cur_slot == SW'(FIRST + i)) hit = slot_en[i];
  end

  assign due = cur_valid & cur_last & accept & active & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      ovr_flag  <= 1'b0;
    end else begin
      fifo_wr <= due & ~fifo_full;
      if (due & ~fifo_full) fifo_data <= word;
      if (due & fifo_full)  ovr_flag <= 1'b1;
      else if (clr_ovr)     ovr_flag <= 1'b0;
    end
  end

  // R9: no write is issued against a full FIFO
  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> !$past(fifo_full));
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !clr_ovr) |=> ovr_flag);
  // R4: writes are single pulses and come only from accepted frames
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |=> !fifo_wr);
  a_r4_write_needs_accept: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(accept));
endmodule

// File: rtl/ac97_rx_slot_check.sv
module ac97_rx_slot_check
  import ac97_rx_pkg::*;
#(
  parameter int TAG_W   = AC_TAG_W,
  parameter int SLOT_W  = AC_SLOT_W,
  parameter int N_SLOTS = AC_NUM_SLOTS,
  parameter int FIRST   = AC_FIRST_DAT,
  parameter int N_DAT   = AC_NUM_DAT,
  localparam int SW     = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              sync_in,
  input  logic              sdata_in,
  input  logic              mode_ac97,
  input  logic              ac97_en,
  input  logic [N_DAT-1:0]  exp_mask,
  input  logic              clr_unexp,
  input  logic              clr_ovr,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [SLOT_W-1:0] fifo_data,
  output logic              unexp_flag,
  output logic              ovr_flag
);
  logic              cur_valid;
  logic              cur_last;
  logic [SW-1:0]     cur_slot;
  logic [SLOT_W-1:0] word;
  logic              accept;
  logic [N_DAT-1:0]  slot_en;
  logic              active;

  assign active = mode_ac97 & ac97_en;

  ac97_frame_align #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_align (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sync_in(sync_in), .sdata_in(sdata_in),
    .cur_valid(cur_valid), .cur_last(cur_last), .cur_slot(cur_slot), .word(word));

  ac97_tag_check #(.TAG_W(TAG_W), .FIRST(FIRST), .N_DAT(N_DAT), .SW(SW)) u_tag (
    .clk(clk), .rst(rst), .cur_valid(cur_valid), .cur_last(cur_last), .cur_slot(cur_slot),
    .tag_word(word[TAG_W-1:0]), .active(active), .exp_mask(exp_mask),
    .clr_unexp(clr_unexp), .accept(accept), .slot_en(slot_en), .unexp_flag(unexp_flag));

  ac97_fifo_feed #(.SLOT_W(SLOT_W), .FIRST(FIRST), .N_DAT(N_DAT), .SW(SW)) u_feed (
    .clk(clk), .rst(rst), .cur_valid(cur_valid), .cur_last(cur_last), .cur_slot(cur_slot),
    .word(word), .accept(accept), .slot_en(slot_en), .active(active),
    .fifo_full(fifo_full), .clr_ovr(clr_ovr), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .ovr_flag(ovr_flag));

  // R8: writes only happen while mode and enable are both set
  a_r8_inactive_no_write: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(mode_ac97 && ac97_en));
  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!fifo_wr && !unexp_flag && !ovr_flag));
endmodule

// File: tb/ac97_rx_slot_check_tb.sv
module ac97_rx_slot_check_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0, sync_in = 1'b0, sdata_in = 1'b0;
  logic        mode_ac97 = 1'b0, ac97_en = 1'b0;
  logic [9:0]  exp_mask = '0;
  logic        clr_unexp = 1'b0, clr_ovr = 1'b0, fifo_full = 1'b0;
  logic        fifo_wr;
  logic [19:0] fifo_data;
  logic        unexp_flag, ovr_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cap_n = 0;
  logic [19:0] cap [0:255];

  always #5 clk = ~clk;

  ac97_rx_slot_check dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sync_in(sync_in), .sdata_in(sdata_in),
    .mode_ac97(mode_ac97), .ac97_en(ac97_en), .exp_mask(exp_mask),
    .clr_unexp(clr_unexp), .clr_ovr(clr_ovr), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .unexp_flag(unexp_flag), .ovr_flag(ovr_flag));

  always @(negedge clk) if (fifo_wr) begin
    if (cap_n < 256) cap[cap_n] = fifo_data;
    cap_n = cap_n + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] slot_word(input int s, input int seed);
    return 20'((s * 32'h1357) ^ (seed * 32'h0F0F) ^ 32'h5A5A5);
  endfunction

  // tag bit 15 frame valid, 14:13 status slots, 12-i for data slot 3+i
  function automatic logic [15:0] tag_for(input logic [9:0] m, input logic [1:0] st);
    logic [15:0] t;
    t = 16'h8000;
    t[14:13] = st;
    for (int i = 0; i < 10; i++) t[12-i] = m[i];
    return t;
  endfunction

  task automatic tick_bit(input logic s, input logic d);
    @(negedge clk);
    sync_in = s; sdata_in = d; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] tag, input int seed, input int upto);
    logic [19:0] w;
    for (int b = 0; b < 16; b++) tick_bit(1'b1, tag[15-b]);
    for (int s = 1; s <= upto; s++) begin
      w = slot_word(s, seed);
      for (int b = 0; b < 20; b++) tick_bit(1'b0, w[19-b]);
    end
    tick_bit(1'b0, 1'b0);
    tick_bit(1'b0, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_words(input string req, input logic [9:0] m, input int seed, input int base);
    int k;
    k = 0;
    chk(cap_n - base == $countones(m), {req, " write count"}, cap_n - base, $countones(m));
    for (int i = 0; i < 10; i++) if (m[i]) begin
      chk(cap[base+k] == slot_word(3+i, seed), {req, " slot word order"}, cap[base+k], slot_word(3+i, seed));
      k++;
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(fifo_wr == 0, "R1 fifo_wr", fifo_wr, 0);
    chk(unexp_flag == 0, "R1 unexp_flag", unexp_flag, 0);
    chk(ovr_flag == 0, "R1 ovr_flag", ovr_flag, 0);
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!fifo_wr && !unexp_flag && !ovr_flag, "R1 after release", {fifo_wr, unexp_flag, ovr_flag}, 0);
  endtask

  task automatic t_match;
    int base;
    mode_ac97 = 1; ac97_en = 1; exp_mask = 10'b0001001011;
    tick_bit(0, 1); tick_bit(0, 0); tick_bit(0, 1);   // idle bits before the frame (R2)
    base = cap_n;
    send_frame(tag_for(exp_mask, 2'b01), 1, 12);
    check_words("R4 R3 partial mask", exp_mask, 1, base);
    chk(unexp_flag == 0, "R5 no flag on match", unexp_flag, 0);
  endtask

  task automatic t_match_all;
    int base;
    exp_mask = 10'h3FF; base = cap_n;
    send_frame(tag_for(exp_mask, 2'b11), 2, 12);
    check_words("R4 all slots", exp_mask, 2, base);
  endtask

  task automatic t_mismatch_sticky;
    int base;
    exp_mask = 10'h00F; base = cap_n;
    send_frame(tag_for(10'h00E, 2'b00), 3, 12);
    chk(cap_n == base, "R5 no writes on mismatch", cap_n - base, 0);
    chk(unexp_flag == 1, "R5 flag on mismatch", unexp_flag, 1);
    base = cap_n;
    send_frame(tag_for(10'h00F, 2'b00), 4, 12);
    check_words("R7 match after mismatch", 10'h00F, 4, base);
    chk(unexp_flag == 1, "R7 flag sticky", unexp_flag, 1);
    pulse(clr_unexp);
    chk(unexp_flag == 0, "R7 flag cleared", unexp_flag, 0);
  endtask

  task automatic t_empty;
    int base;
    exp_mask = 10'h0F1; base = cap_n;
    send_frame(16'h8000, 5, 12);
    chk(cap_n == base && unexp_flag == 0, "R6 empty frame", {cap_n - base, unexp_flag}, 0);
    send_frame(16'hE000, 6, 12);
    chk(cap_n == base && unexp_flag == 0, "R6 status-only frame", {cap_n - base, unexp_flag}, 0);
  endtask

  task automatic t_inactive;
    int base;
    exp_mask = 10'h0F1; base = cap_n;
    mode_ac97 = 0; ac97_en = 1;
    send_frame(tag_for(10'h001, 2'b00), 7, 12);
    chk(unexp_flag == 0, "R8 mode off no flag", unexp_flag, 0);
    send_frame(tag_for(10'h0F1, 2'b00), 8, 12);
    chk(cap_n == base, "R8 mode off no writes", cap_n - base, 0);
    mode_ac97 = 1; ac97_en = 0;
    send_frame(tag_for(10'h0F1, 2'b00), 9, 12);
    chk(cap_n == base, "R8 enable off no writes", cap_n - base, 0);
    send_frame(tag_for(10'h002, 2'b00), 10, 12);
    chk(unexp_flag == 0, "R8 enable off no flag", unexp_flag, 0);
    ac97_en = 1;
  endtask

  task automatic t_overrun;
    int base;
    exp_mask = 10'h210; base = cap_n;
    fifo_full = 1;
    send_frame(tag_for(exp_mask, 2'b00), 11, 12);
    chk(cap_n == base, "R9 dropped when full", cap_n - base, 0);
    chk(ovr_flag == 1, "R9 overrun set", ovr_flag, 1);
    fifo_full = 0; base = cap_n;
    send_frame(tag_for(exp_mask, 2'b00), 12, 12);
    check_words("R9 writes resume", exp_mask, 12, base);
    chk(ovr_flag == 1, "R9 overrun sticky", ovr_flag, 1);
    pulse(clr_ovr);
    chk(ovr_flag == 0, "R9 overrun cleared", ovr_flag, 0);
  endtask

  task automatic t_resync;
    int base;
    exp_mask = 10'h005; base = cap_n;
    send_frame(tag_for(exp_mask, 2'b00), 13, 2);   // cut short after slot 2
    send_frame(tag_for(exp_mask, 2'b00), 14, 12);
    check_words("R2 realign on new sync", exp_mask, 14, base);
    chk(unexp_flag == 0, "R2 no flag after realign", unexp_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_match();
    t_match_all();
    t_mismatch_sticky();
    t_empty();
    t_inactive();
    t_overrun();
    t_resync();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule